// File: doc/BRIEF.md
# Packet FIFO Interrupt Status Register

This block keeps the eight status flags of a packet transceiver that owns a transmit FIFO and a receive FIFO. Each flag has its own rule for setting and clearing. Some follow FIFO fill levels compared against programmable thresholds. Some follow events from the packet engine: transmission start, completion and abort; sync word acknowledgement; reception completion and abort; and a failed CRC comparison. One flag follows an external interrupt line.

An 8-bit enable mask picks which flags drive the single interrupt output. The flags keep updating whether or not they are enabled, so the status byte can be polled at any time. The FIFO storage, the CRC engine and the register bus are outside the block. Their effects reach it as counts, thresholds and single-cycle strobes.

Every flag is a register. It takes its new value on the rising clock edge that samples the stimulus. The interrupt output follows the registered status and the enable mask with no further delay.

Top module: `pfis_top`

## Requirements
- R1: During reset and right after it, `status` is 0. Bit positions in `status`, MSB first, are: 7 FIFO error, 6 TX almost full, 5 TX almost empty, 4 RX almost full, 3 external, 2 packet sent, 1 packet valid, 0 CRC error. A flag changes on the first clock edge that samples its cause.
- R2: Bit 7 sets on any of `txOverflow`, `txUnderflow`, `rxOverflow` or `rxUnderflow`. It clears only after every FIFO that caused an error has had its reset strobe (`txFifoRst`, `rxFifoRst`). A reset of the other FIFO leaves it set.
- R3: Bit 6 sets when `txCount` > `txAfThr`. It clears when `txCount` <= `txAfThr`, but only while a transmission is in progress, which runs from the cycle after `txStart` until `txDone` or `txAbort`. While idle it holds.
- R4: Bit 5 is 1 when `txCount` <= `txAeThr` and 0 when `txCount` > `txAeThr`.
- R5: Bit 4 sets when `rxCount` > `rxAfThr` and clears when `rxCount` < `rxAfThr`. When the two are equal it holds its value.
- R6: Bit 3 follows `extIrq`, one cycle late.
- R7: Bit 2 sets on `txDone` when no `txAbort` has occurred since the last `txStart`. It clears on `txStart` or on a 1-to-0 change of `fifoMode`.
- R8: Bit 1 sets on `rxDone` when no `rxAbort` has occurred since the last `syncAck`. It clears on `syncAck`.
- R9: Bit 0 sets on `crcFail` and clears on `syncAck`.
- R10: `irq` is 1 exactly when some bit of `status & irqEn` is 1. The status bits update regardless of `irqEn`.
- R11: When a set cause and a clear cause for a bit land in the same cycle, the bit ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txCount | input | CNT_W | Untransmitted bytes in the TX FIFO |
| rxCount | input | CNT_W | Unread bytes in the RX FIFO |
| txAfThr | input | THR_W | TX almost-full threshold |
| txAeThr | input | THR_W | TX almost-empty threshold |
| rxAfThr | input | THR_W | RX almost-full threshold |
| txFifoRst | input | 1 | TX FIFO reset strobe |
| rxFifoRst | input | 1 | RX FIFO reset strobe |
| txOverflow | input | 1 | TX FIFO overflow pulse |
| txUnderflow | input | 1 | TX FIFO underflow pulse |
| rxOverflow | input | 1 | RX FIFO overflow pulse |
| rxUnderflow | input | 1 | RX FIFO underflow pulse |
| txStart | input | 1 | Transmission start strobe |
| txDone | input | 1 | Transmission complete strobe |
| txAbort | input | 1 | Transmission abort strobe |
| syncAck | input | 1 | Sync word received and acknowledged |
| rxDone | input | 1 | Reception complete strobe |
| rxAbort | input | 1 | Reception abort strobe |
| crcFail | input | 1 | Received CRC differs from computed CRC |
| extIrq | input | 1 | External interrupt source |
| fifoMode | input | 1 | FIFO packet mode active |
| irqEn | input | 8 | Interrupt enable mask, one bit per status bit |
| status | output | 8 | Status byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with a FIFO depth of 16, so counts are 5 bits and thresholds are 4 bits. At that size every threshold can be paired with every fill level. The almost-empty flag is checked over all 17 counts for each of the 16 thresholds. The RX almost-full hysteresis is checked by ramping the count up and back down under each threshold. The TX almost-full flag is checked at each threshold, idle and during a transmission. All 256 enable masks are checked against a known status byte. The event flags, the error-source tracking and same-cycle set/clear collisions are checked with directed sequences.

// File: rtl/pfis_pkg.sv
package pfis_pkg;
  localparam int NUM_BITS   = 8;
  localparam int BIT_FERR   = 7;
  localparam int BIT_TXAF   = 6;
  localparam int BIT_TXAE   = 5;
  localparam int BIT_RXAF   = 4;
  localparam int BIT_EXT    = 3;
  localparam int BIT_PSENT  = 2;
  localparam int BIT_PVALID = 1;
  localparam int BIT_CRC    = 0;

  // Strobes from the control to the status datapath
  typedef struct packed {
    logic [NUM_BITS-1:0] setBit;
    logic [NUM_BITS-1:0] clrBit;
    logic                txErrSet;
    logic                rxErrSet;
    logic                txErrClr;
    logic                rxErrClr;
  } statStrobes_t;
endpackage

// File: rtl/pfis_ctrl.sv
module pfis_ctrl
  import pfis_pkg::*;
#(
  parameter int CNT_W = 7,
  parameter int THR_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] txCount,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [THR_W-1:0] txAfThr,
  input  logic [THR_W-1:0] txAeThr,
  input  logic [THR_W-1:0] rxAfThr,
  input  logic             txFifoRst,
  input  logic             rxFifoRst,
  input  logic             txOverflow,
  input  logic             txUnderflow,
  input  logic             rxOverflow,
  input  logic             rxUnderflow,
  input  logic             txStart,
  input  logic             txDone,
  input  logic             txAbort,
  input  logic             syncAck,
  input  logic             rxDone,
  input  logic             rxAbort,
  input  logic             crcFail,
  input  logic             extIrq,
  input  logic             fifoMode,
  output statStrobes_t     strobes
);
  localparam int PAD_W = CNT_W - THR_W;

  logic             txBusyQ;
  logic             txAbortedQ;
  logic             rxAbortedQ;
  logic             fifoModeQ;
  logic [CNT_W-1:0] txAfLim;
  logic [CNT_W-1:0] txAeLim;
  logic [CNT_W-1:0] rxAfLim;

  assign txAfLim = {{PAD_W{1'b0}}, txAfThr};
  assign txAeLim = {{PAD_W{1'b0}}, txAeThr};
  assign rxAfLim = {{PAD_W{1'b0}}, rxAfThr};

  // Packet engine tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusyQ    <= 1'b0;
      txAbortedQ <= 1'b0;
      rxAbortedQ <= 1'b0;
      fifoModeQ  <= 1'b0;
    end else begin
      if (txStart)                txBusyQ <= 1'b1;
      else if (txDone || txAbort) txBusyQ <= 1'b0;

      if (txStart)      txAbortedQ <= 1'b0;
      else if (txAbort) txAbortedQ <= 1'b1;

      if (rxAbort)      rxAbortedQ <= 1'b1;
      else if (syncAck) rxAbortedQ <= 1'b0;

      fifoModeQ <= fifoMode;
    end
  end

  always_comb begin
    strobes = '0;
    strobes.txErrSet = txOverflow | txUnderflow;
    strobes.rxErrSet = rxOverflow | rxUnderflow;
    strobes.txErrClr = txFifoRst;
    strobes.rxErrClr = rxFifoRst;
    strobes.setBit[BIT_FERR] = strobes.txErrSet | strobes.rxErrSet;
    strobes.clrBit[BIT_FERR] = strobes.txErrClr | strobes.rxErrClr;

    strobes.setBit[BIT_TXAF] = txCount > txAfLim;
    strobes.clrBit[BIT_TXAF] = txBusyQ && (txCount <= txAfLim);

    strobes.setBit[BIT_TXAE] = txCount <= txAeLim;
    strobes.clrBit[BIT_TXAE] = txCount > txAeLim;

    strobes.setBit[BIT_RXAF] = rxCount > rxAfLim;
    strobes.clrBit[BIT_RXAF] = rxCount < rxAfLim;

    strobes.setBit[BIT_EXT] = extIrq;
    strobes.clrBit[BIT_EXT] = !extIrq;

    strobes.setBit[BIT_PSENT] = txDone && !txAbort && !txAbortedQ;
    strobes.clrBit[BIT_PSENT] = txStart || (fifoModeQ && !fifoMode);

    strobes.setBit[BIT_PVALID] = rxDone && !rxAbort && !rxAbortedQ;
    strobes.clrBit[BIT_PVALID] = syncAck;

    strobes.setBit[BIT_CRC] = crcFail;
    strobes.clrBit[BIT_CRC] = syncAck;
  end

  // R3
  txaf_idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!txBusyQ && !(txCount > txAfLim)) |-> !strobes.setBit[BIT_TXAF] && !strobes.clrBit[BIT_TXAF]);

  // R7
  abort_blocks_sent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txAbort && !txStart) |=> !strobes.setBit[BIT_PSENT] || txStart);
endmodule

// File: rtl/pfis_datapath.sv
module pfis_datapath
  import pfis_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  statStrobes_t        strobes,
  input  logic [NUM_BITS-1:0] irqEn,
  output logic [NUM_BITS-1:0] status,
  output logic                irq
);
  logic [BIT_FERR-1:0] bitsQ;
  logic                txErrQ;
  logic                rxErrQ;

  // Per-bit set/clear flags, set has priority
  for (genvar i = 0; i < BIT_FERR; i++) begin : g_flag
    logic flagQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                     flagQ <= 1'b0;
      else if (strobes.setBit[i])    flagQ <= 1'b1;
      else if (strobes.clrBit[i])    flagQ <= 1'b0;
    end
    assign bitsQ[i] = flagQ;

    // R1
    clr_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.clrBit[i] && !strobes.setBit[i]) |=> !status[i]);
  end

  // Error source flags, one per FIFO
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txErrQ <= 1'b0;
      rxErrQ <= 1'b0;
    end else begin
      if (strobes.txErrSet)      txErrQ <= 1'b1;
      else if (strobes.txErrClr) txErrQ <= 1'b0;
      if (strobes.rxErrSet)      rxErrQ <= 1'b1;
      else if (strobes.rxErrClr) rxErrQ <= 1'b0;
    end
  end

  assign status = {txErrQ | rxErrQ, bitsQ};
  assign irq    = |(status & irqEn);

  for (genvar j = 0; j < NUM_BITS; j++) begin : g_setchk
    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobes.setBit[j] |=> status[j]);
  end

  // R2
  err_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(status[BIT_FERR]) |-> $past(strobes.clrBit[BIT_FERR]));
endmodule

// File: rtl/pfis_top.sv
module pfis_top
  import pfis_pkg::*;
#(
  parameter int  FIFO_DEPTH = 64,
  localparam int CNT_W      = $clog2(FIFO_DEPTH) + 1,
  localparam int THR_W      = $clog2(FIFO_DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] txCount,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [THR_W-1:0] txAfThr,
  input  logic [THR_W-1:0] txAeThr,
  input  logic [THR_W-1:0] rxAfThr,
  input  logic             txFifoRst,
  input  logic             rxFifoRst,
  input  logic             txOverflow,
  input  logic             txUnderflow,
  input  logic             rxOverflow,
  input  logic             rxUnderflow,
  input  logic             txStart,
  input  logic             txDone,
  input  logic             txAbort,
  input  logic             syncAck,
  input  logic             rxDone,
  input  logic             rxAbort,
  input  logic             crcFail,
  input  logic             extIrq,
  input  logic             fifoMode,
  input  logic [7:0]       irqEn,
  output logic [7:0]       status,
  output logic             irq
);
  statStrobes_t strobes;

  pfis_ctrl #(.CNT_W(CNT_W), .THR_W(THR_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .txCount(txCount), .rxCount(rxCount),
    .txAfThr(txAfThr), .txAeThr(txAeThr), .rxAfThr(rxAfThr),
    .txFifoRst(txFifoRst), .rxFifoRst(rxFifoRst),
    .txOverflow(txOverflow), .txUnderflow(txUnderflow),
    .rxOverflow(rxOverflow), .rxUnderflow(rxUnderflow),
    .txStart(txStart), .txDone(txDone), .txAbort(txAbort),
    .syncAck(syncAck), .rxDone(rxDone), .rxAbort(rxAbort),
    .crcFail(crcFail), .extIrq(extIrq), .fifoMode(fifoMode),
    .strobes(strobes)
  );

  pfis_datapath dp_i (
    .clk(clk), .rstN(rstN),
    .strobes(strobes), .irqEn(irqEn),
    .status(status), .irq(irq)
  );

  // R6
  ext_follow_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
    extIrq |=> status[BIT_EXT]);
  // R6
  ext_follow_lo_chk: assert property (@(posedge clk) disable iff (!rstN)
    !extIrq |=> !status[BIT_EXT]);
  // R7
  sent_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[BIT_PSENT]) |-> $past(txDone));
  // R8
  valid_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[BIT_PVALID]) |-> $past(rxDone));
  // R9
  crc_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[BIT_CRC]) |-> $past(crcFail));
  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqEn == 8'h00) |-> !irq);
endmodule

// File: tb/pfis_top_tb_top.sv
`timescale 1ns/1ps
module pfis_top_tb_top;
  localparam int DEPTH = 16;
  localparam int CNT_W = 5;
  localparam int THR_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CNT_W-1:0] txCount = '0, rxCount = '0;
  logic [THR_W-1:0] txAfThr = '0, txAeThr = '0, rxAfThr = '0;
  logic txFifoRst = 0, rxFifoRst = 0, txOverflow = 0, txUnderflow = 0;
  logic rxOverflow = 0, rxUnderflow = 0, txStart = 0, txDone = 0, txAbort = 0;
  logic syncAck = 0, rxDone = 0, rxAbort = 0, crcFail = 0, extIrq = 0, fifoMode = 1;
  logic [7:0] irqEn = 8'hFF;
  logic [7:0] status;
  logic irq;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  pfis_top #(.FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .txCount(txCount), .rxCount(rxCount),
    .txAfThr(txAfThr), .txAeThr(txAeThr), .rxAfThr(rxAfThr),
    .txFifoRst(txFifoRst), .rxFifoRst(rxFifoRst),
    .txOverflow(txOverflow), .txUnderflow(txUnderflow),
    .rxOverflow(rxOverflow), .rxUnderflow(rxUnderflow),
    .txStart(txStart), .txDone(txDone), .txAbort(txAbort),
    .syncAck(syncAck), .rxDone(rxDone), .rxAbort(rxAbort), .crcFail(crcFail),
    .extIrq(extIrq), .fifoMode(fifoMode), .irqEn(irqEn),
    .status(status), .irq(irq)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearPulses();
    txFifoRst = 0; rxFifoRst = 0; txOverflow = 0; txUnderflow = 0;
    rxOverflow = 0; rxUnderflow = 0; txStart = 0; txDone = 0; txAbort = 0;
    syncAck = 0; rxDone = 0; rxAbort = 0; crcFail = 0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic rxModel;
    logic [7:0] snap;
    // R1 reset state
    step();
    step();
    chk("R1 status in reset", status, 8'h00);
    chk("R1 irq in reset", {7'd0, irq}, 8'h00);
    rstN = 1'b1;
    chk("R1 status after reset", status, 8'h00);

    // R4 full sweep of TX almost-empty
    for (int thr = 0; thr < DEPTH; thr++) begin
      for (int cnt = 0; cnt <= DEPTH; cnt++) begin
        txAeThr = THR_W'(thr);
        txCount = CNT_W'(cnt);
        step();
        chk("R4 tx almost empty", {7'd0, status[5]}, {7'd0, cnt <= thr});
      end
    end

    // R3 TX almost-full, idle hold and drain clear
    for (int thr = 0; thr < DEPTH; thr++) begin
      txAfThr = THR_W'(thr);
      txCount = CNT_W'(thr + 1);
      step();
      chk("R3 tx af set", {7'd0, status[6]}, 8'd1);
      txCount = CNT_W'(thr);
      step();
      chk("R3 tx af idle hold", {7'd0, status[6]}, 8'd1);
      txStart = 1; step(); txStart = 0;
      step();
      chk("R3 tx af drain clear", {7'd0, status[6]}, 8'd0);
      txCount = CNT_W'(thr + 1);
      step();
      chk("R3 tx af set while busy", {7'd0, status[6]}, 8'd1);
      txDone = 1; step(); txDone = 0;
    end

    // R5 RX almost-full with hysteresis at equality
    rxModel = 1'b0;
    for (int thr = 0; thr < DEPTH; thr++) begin
      rxAfThr = THR_W'(thr);
      for (int k = 0; k <= 2 * DEPTH; k++) begin
        int cnt;
        cnt = (k <= DEPTH) ? k : 2 * DEPTH - k;
        rxCount = CNT_W'(cnt);
        step();
        if (cnt > thr) rxModel = 1'b1;
        else if (cnt < thr) rxModel = 1'b0;
        chk("R5 rx almost full", {7'd0, status[4]}, {7'd0, rxModel});
      end
    end

    // R2 FIFO error per source
    for (int src = 0; src < 4; src++) begin
      txOverflow = (src == 0); txUnderflow = (src == 1);
      rxOverflow = (src == 2); rxUnderflow = (src == 3);
      step(); clearPulses();
      chk("R2 error set", {7'd0, status[7]}, 8'd1);
      if (src < 2) rxFifoRst = 1; else txFifoRst = 1;
      step(); clearPulses();
      chk("R2 other fifo reset keeps error", {7'd0, status[7]}, 8'd1);
      if (src < 2) txFifoRst = 1; else rxFifoRst = 1;
      step(); clearPulses();
      chk("R2 own fifo reset clears", {7'd0, status[7]}, 8'd0);
    end
    txOverflow = 1; rxUnderflow = 1; step(); clearPulses();
    txFifoRst = 1; step(); clearPulses();
    chk("R2 rx source still pending", {7'd0, status[7]}, 8'd1);
    rxFifoRst = 1; step(); clearPulses();
    chk("R2 both sources released", {7'd0, status[7]}, 8'd0);
    // R11 error set and reset together
    txOverflow = 1; txFifoRst = 1; step(); clearPulses();
    chk("R11 error set beats reset", {7'd0, status[7]}, 8'd1);
    txFifoRst = 1; step(); clearPulses();
    chk("R2 error clear after collision", {7'd0, status[7]}, 8'd0);

    // R6 external
    extIrq = 1; step();
    chk("R6 ext high", {7'd0, status[3]}, 8'd1);
    extIrq = 0; step();
    chk("R6 ext low", {7'd0, status[3]}, 8'd0);

    // R7 packet sent
    txStart = 1; step(); clearPulses();
    chk("R7 start clears sent", {7'd0, status[2]}, 8'd0);
    txDone = 1; step(); clearPulses();
    chk("R7 sent set", {7'd0, status[2]}, 8'd1);
    txStart = 1; step(); clearPulses();
    chk("R7 new start clears", {7'd0, status[2]}, 8'd0);
    txDone = 1; step(); clearPulses();
    fifoMode = 0; step();
    chk("R7 leaving fifo mode clears", {7'd0, status[2]}, 8'd0);
    fifoMode = 1; step();
    txStart = 1; step(); clearPulses();
    txAbort = 1; step(); clearPulses();
    txDone = 1; step(); clearPulses();
    chk("R7 abort blocks sent", {7'd0, status[2]}, 8'd0);
    txStart = 1; step(); clearPulses();
    txDone = 1; step(); clearPulses();
    chk("R7 sent after abort cleared", {7'd0, status[2]}, 8'd1);
    txStart = 1; txDone = 1; step(); clearPulses();
    chk("R11 sent set beats start clear", {7'd0, status[2]}, 8'd1);

    // R8 and R9 reception
    syncAck = 1; step(); clearPulses();
    rxDone = 1; step(); clearPulses();
    chk("R8 valid set", {6'd0, status[1:0]}, 8'b10);
    syncAck = 1; step(); clearPulses();
    chk("R8 sync clears valid", {6'd0, status[1:0]}, 8'b00);
    rxDone = 1; crcFail = 1; step(); clearPulses();
    chk("R9 crc error set", {6'd0, status[1:0]}, 8'b11);
    syncAck = 1; step(); clearPulses();
    chk("R9 sync clears crc", {6'd0, status[1:0]}, 8'b00);
    rxAbort = 1; step(); clearPulses();
    rxDone = 1; step(); clearPulses();
    chk("R8 abort blocks valid", {7'd0, status[1]}, 8'd0);
    syncAck = 1; step(); clearPulses();
    rxDone = 1; step(); clearPulses();
    chk("R8 valid after new sync", {7'd0, status[1]}, 8'd1);
    syncAck = 1; crcFail = 1; step(); clearPulses();
    chk("R11 crc set beats sync clear", {7'd0, status[0]}, 8'd1);

    // R10 enable mask sweep on a held status byte
    extIrq = 1; step();
    snap = status;
    chk("R10 ext present in snapshot", {7'd0, snap[3]}, 8'd1);
    for (int en = 0; en < 256; en++) begin
      irqEn = 8'(en);
      #1;
      chk("R10 irq mask", {7'd0, irq}, {7'd0, (snap & 8'(en)) != 8'd0});
    end
    irqEn = 8'h00;
    extIrq = 0; step();
    chk("R10 status updates while masked", {7'd0, status[3]}, 8'd0);
    chk("R10 irq low while masked", {7'd0, irq}, 8'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule